// File: doc/BRIEF.md
# Predicated-Block Control-Flow Fault Checker

This block sits in an instruction decode stage. It follows a predicated block of one to four instructions that a block-open instruction starts. For every decoded instruction it gets three inputs: a class code, a flag saying the instruction writes the program counter, and a flag saying the same instruction would already be unpredictable outside a block. It reports whether the instruction occupies the final slot of the running block. It also raises an undefined-instruction usage fault when the instruction's class is not allowed at that position.

Some classes are illegal anywhere inside a block. Others are legal only in the final slot. A block-open instruction carries the block length on `in_len`, coded as length minus one. Instructions arrive on a valid/ready stream and the verdict leaves on a registered valid/ready stream. An instruction is accepted when `in_valid && in_ready`. `in_ready` is high whenever the output register is empty or is being drained in that cycle. While `out_valid` is high and `out_ready` is low, the input stalls and the verdict holds steady.

Top module: `pbf_checker`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and no block is active.
- R2: A block-open instruction (class 3) accepted outside a block opens a block of `in_len`+1 instructions. Within the block, the Nth accepted instruction reports `out_last`=1 and all other instructions report 0. The block-open instruction itself, and any instruction outside a block, report 0.
- R3: Inside a block, a conditional branch (class 1), a compare-and-branch (class 2), a processor-state change (class 4) and a linked exchange branch through the PC (class 11) fault in every slot.
- R4: A block-open instruction (class 3) accepted inside a block faults and does not restart or lengthen the block.
- R5: Inside a block, the unconditional branch (5), linked branch (6), exchange branch (7) and table branch (8) classes fault in every slot except the final one.
- R6: Inside a block, the data-processing (9) and load (10) classes fault in a non-final slot only when `in_pcdst`=1 and `in_unp_out`=0. They never fault otherwise.
- R7: Classes 0, 12 and 13 to 15 (including the predicated floating-point select and rounding group, class 12) never fault.
- R8: A faulting instruction still uses up its slot. When it sits in the final slot, the block ends.
- R9: Outside a block, no instruction of any class faults.
- R10: `in_ready` is high exactly when `out_valid` is 0 or `out_ready` is 1. While `out_valid`=1 and `out_ready`=0, `out_last` and `out_fault` stay unchanged.
- R11: Asserting reset in the middle of a block ends that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Checker can accept an instruction |
| in_cls | input | 4 | Instruction class code |
| in_len | input | 2 | Block length minus one, used with class 3 |
| in_pcdst | input | 1 | Instruction writes the program counter |
| in_unp_out | input | 1 | Instruction is unpredictable even outside a block |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_last | output | 1 | Instruction occupied the final slot |
| out_fault | output | 1 | Undefined-instruction usage fault |

## Verification
A fault and the closing of a block can happen on the same accepted instruction. The sweep forces this by placing every class, including a nested block-open, in the final slot of blocks of every length. Each such block is followed by a plain instruction. That instruction must show `out_last`=0 and no fault, which proves the faulting instruction used up the last slot and did not restart anything. A stalled verdict held under back-pressure is judged against the next instruction accepted once `out_ready` returns.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  typedef enum logic [3:0] {
    CLS_PLAIN   = 4'd0,
    CLS_BCOND   = 4'd1,
    CLS_CMPBR   = 4'd2,
    CLS_BLKOPEN = 4'd3,
    CLS_PSTATE  = 4'd4,
    CLS_BR      = 4'd5,
    CLS_BRLINK  = 4'd6,
    CLS_BRXCH   = 4'd7,
    CLS_TBLBR   = 4'd8,
    CLS_ALU     = 4'd9,
    CLS_LOAD    = 4'd10,
    CLS_BLXPC   = 4'd11,
    CLS_FPCOND  = 4'd12
  } cls_e;

  typedef struct packed {
    logic last;
    logic fault;
  } verdict_t;
endpackage

// File: rtl/pbf_slot_track.sv
module pbf_slot_track #(
  parameter int MAX_LEN = 4,
  parameter int CW = $clog2(MAX_LEN + 1),
  parameter int LW = $clog2(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          open_req,
  input  logic [LW-1:0] len_m1,
  output logic          active,
  output logic          at_last,
  output logic [CW-1:0] cnt
);
  // slots left in the running block; zero means no block
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (acc) begin
      if (cnt != '0) cnt <= cnt - CW'(1);
      else if (open_req) cnt <= CW'(len_m1) + CW'(1);
    end
  end

  assign active  = (cnt != '0);
  assign at_last = (cnt == CW'(1));
endmodule

// File: rtl/pbf_rules.sv
module pbf_rules #(
  parameter int CLSW = 4
) (
  input  logic [CLSW-1:0] cls,
  input  logic            active,
  input  logic            at_last,
  input  logic            pcdst,
  input  logic            unp_out,
  output pbf_pkg::verdict_t v
);
  import pbf_pkg::*;
  localparam int NCLS = 1 << CLSW;

  logic [NCLS-1:0] always_m, notlast_m, pcw_m;

  // per-class rule masks, one generate slot per code
  for (genvar i = 0; i < NCLS; i++) begin : g_mask
    assign always_m[i]  = (i == int'(CLS_BCOND)) || (i == int'(CLS_CMPBR)) ||
                          (i == int'(CLS_BLKOPEN)) || (i == int'(CLS_PSTATE)) ||
                          (i == int'(CLS_BLXPC));
    assign notlast_m[i] = (i == int'(CLS_BR)) || (i == int'(CLS_BRLINK)) ||
                          (i == int'(CLS_BRXCH)) || (i == int'(CLS_TBLBR));
    assign pcw_m[i]     = (i == int'(CLS_ALU)) || (i == int'(CLS_LOAD));
  end

  always_comb begin
    v.last  = active && at_last;
    v.fault = active && (always_m[cls] ||
              (!at_last && (notlast_m[cls] || (pcw_m[cls] && pcdst && !unp_out))));
  end
endmodule

// File: rtl/pbf_out_reg.sv
module pbf_out_reg (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  pbf_pkg::verdict_t v_in,
  input  logic              out_ready,
  output logic              out_valid,
  output pbf_pkg::verdict_t v_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      v_out     <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      v_out     <= v_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pbf_checker.sv
module pbf_checker #(
  parameter int MAX_LEN = 4,
  parameter int CLSW = 4,
  localparam int CW = $clog2(MAX_LEN + 1),
  localparam int LW = $clog2(MAX_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CLSW-1:0] in_cls,
  input  logic [LW-1:0]   in_len,
  input  logic            in_pcdst,
  input  logic            in_unp_out,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_last,
  output logic            out_fault
);
  import pbf_pkg::*;

  logic          acc;
  logic          blk_active, blk_at_last;
  logic [CW-1:0] blk_cnt;
  verdict_t      v_now, v_reg;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  pbf_slot_track #(.MAX_LEN(MAX_LEN), .CW(CW), .LW(LW)) u_track (
    .clk(clk), .rst(rst), .acc(acc),
    .open_req(in_cls == CLSW'(CLS_BLKOPEN)),
    .len_m1(in_len), .active(blk_active), .at_last(blk_at_last), .cnt(blk_cnt)
  );

  pbf_rules #(.CLSW(CLSW)) u_rules (
    .cls(in_cls), .active(blk_active), .at_last(blk_at_last),
    .pcdst(in_pcdst), .unp_out(in_unp_out), .v(v_now)
  );

  pbf_out_reg u_oreg (
    .clk(clk), .rst(rst), .acc(acc), .v_in(v_now),
    .out_ready(out_ready), .out_valid(out_valid), .v_out(v_reg)
  );

  assign out_last  = v_reg.last;
  assign out_fault = v_reg.fault;
endmodule

// File: rtl/pbf_checker_sva.sv
module pbf_checker_sva #(
  parameter int CLSW = 4,
  parameter int CW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [CLSW-1:0] in_cls,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_last,
  input logic            out_fault,
  input logic [CW-1:0]   blk_cnt
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (blk_cnt == '0 && !out_valid));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable({out_last, out_fault}));

  a_r10_empty_ready: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  a_r9_open_clean: assert property (@(posedge clk) disable iff (rst)
    acc && blk_cnt == '0 |=> out_valid && !out_fault && !out_last);

  a_r3_always: assert property (@(posedge clk) disable iff (rst)
    acc && blk_cnt != '0 && (in_cls == 4'd1 || in_cls == 4'd2 ||
    in_cls == 4'd4 || in_cls == 4'd11) |=> out_fault);

  a_r5_last_ok: assert property (@(posedge clk) disable iff (rst)
    acc && blk_cnt == CW'(1) && in_cls >= 4'd5 && in_cls <= 4'd8
    |=> !out_fault && out_last);

  a_r7_plain: assert property (@(posedge clk) disable iff (rst)
    acc && (in_cls == 4'd0 || in_cls == 4'd12) |=> !out_fault);

  a_r8_consume: assert property (@(posedge clk) disable iff (rst)
    acc && blk_cnt != '0 |=> blk_cnt == $past(blk_cnt) - CW'(1));
endmodule

bind pbf_checker pbf_checker_sva #(.CLSW(CLSW), .CW(CW)) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_cls(in_cls), .out_valid(out_valid), .out_ready(out_ready),
  .out_last(out_last), .out_fault(out_fault), .blk_cnt(blk_cnt)
);

// File: tb/pbf_checker_tb.sv
module pbf_checker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_pcdst = 1'b0, in_unp_out = 1'b0, out_ready = 1'b1;
  logic [3:0] in_cls = '0;
  logic [1:0] in_len = '0;
  logic in_ready, out_valid, out_last, out_fault;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pbf_checker u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_len(in_len), .in_pcdst(in_pcdst),
    .in_unp_out(in_unp_out), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_fault(out_fault)
  );

  function automatic bit exp_fault(int c, bit inblk, bit last, bit pcd, bit unp);
    if (!inblk) return 1'b0;
    case (c)
      1, 2, 3, 4, 11: return 1'b1;
      5, 6, 7, 8:     return !last;
      9, 10:          return !last && pcd && !unp;
      default:        return 1'b0;
    endcase
  endfunction

  function automatic string req_of(int c, bit inblk);
    if (!inblk) return "R9";
    case (c)
      1, 2, 4, 11: return "R3";
      3:           return "R4";
      5, 6, 7, 8:  return "R5";
      9, 10:       return "R6";
      default:     return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one instruction at a negedge, accept at posedge, check at next negedge
  task automatic send(int c, int len, bit pcd, bit unp, bit el, bit ef, string req);
    in_valid = 1'b1; in_cls = 4'(c); in_len = 2'(len - 1);
    in_pcdst = pcd; in_unp_out = unp;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
    chk(out_last == el, req, "out_last", int'(out_last), int'(el));
    chk(out_fault == ef, req, "out_fault", int'(out_fault), int'(ef));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    send(0, 1, 0, 0, 0, 0, "R1");

    // R9: every class outside a block
    for (int c = 0; c < 16; c++) begin
      if (c == 3) continue;
      for (int p = 0; p < 4; p++) send(c, 1, p[0], p[1], 0, 0, "R9");
    end

    // R2 R3 R4 R5 R6 R7 R8: every class in every slot of every length
    for (int len = 1; len <= 4; len++)
      for (int pos = 0; pos < len; pos++)
        for (int c = 0; c < 16; c++)
          for (int p = 0; p < 4; p++) begin
            send(3, len, 0, 0, 0, 0, "R2");
            for (int s = 0; s < len; s++) begin
              bit lst;
              lst = (s == len - 1);
              if (s == pos)
                send(c, 4, p[0], p[1], lst,
                     exp_fault(c, 1'b1, lst, p[0], p[1]), req_of(c, 1'b1));
              else
                send(0, 4, 0, 0, lst, 0, "R2");
            end
            send(0, 1, 0, 0, 0, 0, "R8");
          end

    // R11: reset in the middle of a block
    send(3, 4, 0, 0, 0, 0, "R2");
    send(0, 1, 0, 0, 0, 0, "R2");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R11", "out_valid after mid reset", int'(out_valid), 0);
    send(1, 1, 0, 0, 0, 0, "R11");

    // R10: back-pressure
    send(3, 2, 0, 0, 0, 0, "R10");
    out_ready = 1'b0;
    #1;
    chk(in_ready == 1'b0, "R10", "in_ready stalled", int'(in_ready), 0);
    in_valid = 1'b1; in_cls = 4'd1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b0, "R10", "in_ready still stalled", int'(in_ready), 0);
    chk(out_valid == 1'b1, "R10", "held valid", int'(out_valid), 1);
    chk(out_fault == 1'b0, "R10", "held fault", int'(out_fault), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_fault == 1'b1, "R10", "stalled branch fault", int'(out_fault), 1);
    chk(out_last == 1'b0, "R10", "stalled branch last", int'(out_last), 0);
    send(0, 1, 0, 0, 1, 0, "R10");
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "drained", int'(out_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule